// File: doc/BRIEF.md
# Spin Lock Acquirer with Read Polling and Exponential Backoff

This block obtains and gives back a single spin lock that lives in shared memory, acting for one local client. The client pulses an acquire command; the block then watches the lock word with ordinary loads until a load returns zero. Only then does it issue one atomic test-and-set. A zero returned by the test-and-set means the lock is now owned, and the block raises its grant output. A nonzero result means another agent got there first. The block then sits idle for a backoff delay before it goes back to polling. The delay grows geometrically with each consecutive failure and stops growing at a ceiling.

A release command from the client while the lock is owned makes the block write zero to the lock word with a plain store. Commands that make no sense in the present state are dropped and reported on a one-cycle error pulse. On the memory side there is a valid/ready request channel carrying an operation code and the lock address. A separate response channel returns the old lock value, and only one request is outstanding at a time.

Top module: `tts_lock_requester`

## Requirements
- R1: While reset is applied and after it is released with no command, grant, error and request-valid are all low.
- R2: After an accepted acquire, the first request and every request while the lock is seen busy are loads (operation code 2'b00 on `mem_req_op`); no request is made while no acquire is in progress.
- R3: A test-and-set (operation code 2'b01) is issued only as the very next request after a load whose response data was zero; a load response of zero is never followed by another load.
- R4: A test-and-set whose response data is nonzero is followed, after the backoff delay, by a load.
- R5: The backoff after the i-th consecutive failed test-and-set (i counted from 0) lasts exactly min(BASE_DLY * GROWTH^i, MAX_DLY) cycles: the number of cycles from the cycle after the failing response up to the cycle in which the next load request is presented. The count i returns to 0 when a test-and-set succeeds.
- R6: `granted` rises in the cycle after a test-and-set response with zero data and stays high, with no memory request presented, until the cycle after an accepted release command.
- R7: An accepted release issues exactly one store-zero request (operation code 2'b10) and the block then returns to idle, issuing nothing further until the next acquire.
- R8: An acquire command arriving while an acquisition is under way or the lock is held is ignored, and `cmd_err` is high for one cycle in the following cycle; `granted` is unchanged.
- R9: A release command arriving while the lock is not held is ignored (no memory request results), and `cmd_err` is high in the following cycle.
- R10: A request keeps valid and its operation code stable until it is accepted, and no new request is presented while a response is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acq_cmd | input | 1 | One-cycle acquire command from the client |
| rel_cmd | input | 1 | One-cycle release command from the client |
| granted | output | 1 | High while the lock is owned |
| cmd_err | output | 1 | One-cycle pulse for an ignored command |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted this cycle |
| mem_req_op | output | 2 | 2'b00 load, 2'b01 test-and-set, 2'b10 store zero |
| mem_req_addr | output | ADDR_W | Lock word address (parameter LOCK_ADDR) |
| mem_rsp_valid | input | 1 | Response valid, one per accepted request |
| mem_rsp_data | input | DATA_W | Old lock value; zero means free |

## Verification
The bench models a memory with random acceptance and response latency, and a competing agent. The competitor can hold the lock, or snatch it right after a load has seen it free, which forces the test-and-set to fail. A directed run of eleven consecutive failures walks the delay up to the ceiling and then holds it there. A delay that was off by one cycle, kept growing past the ceiling or failed to restart at the base value after a success would show up as a miscounted gap. Misordered operations are also caught: a test-and-set issued without a zero load before it, or a load repeated after a zero, would betray an acquirer that hammers the atomic path or misses a free lock. The bench also injects acquires while polling and while holding, and releases while idle. A design that acted on these instead of flagging them would drop the grant or put a stray request on the bus.

// File: rtl/lock_req_pkg.sv
package lock_req_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_TAS    = 2'b01,
    OP_STORE0 = 2'b10
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_TRY,
    ST_BACKOFF,
    ST_HELD,
    ST_RELEASE
  } lrq_state_e;

endpackage

// File: rtl/tts_rst_sync.sv
module tts_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  // assert immediately, release after STAGES clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tts_mem_port.sv
module tts_mem_port (
  input  logic clk,
  input  logic rst_n,
  input  logic active,      // the controller wants one transaction
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic done         // response arrived for the issued request
);

  logic sent_q, sent_d, sent_en;

  assign req_valid = active && !sent_q;
  assign done      = active && sent_q && rsp_valid;

  always_comb begin
    sent_d  = sent_q;
    sent_en = 1'b0;
    if (!active || done) begin
      sent_d  = 1'b0;
      sent_en = 1'b1;
    end else if (req_valid && req_ready) begin
      sent_d  = 1'b1;
      sent_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sent_q <= 1'b0;
    else if (sent_en) sent_q <= sent_d;
  end

endmodule

// File: rtl/tts_backoff_timer.sv
module tts_backoff_timer #(
  parameter int unsigned BASE_DLY = 4,
  parameter int unsigned GROWTH   = 2,
  parameter int unsigned MAX_DLY  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,      // failed attempt: start a wait, grow the next one
  input  logic restart,  // success: next wait goes back to the base
  input  logic run,      // waiting
  output logic expired
);

  localparam int unsigned DLY_W  = $clog2(MAX_DLY + 1);
  localparam int unsigned GROW_W = $clog2(GROWTH + 1);
  localparam int unsigned PROD_W = DLY_W + GROW_W;
  localparam logic [DLY_W-1:0] CEIL_V = DLY_W'(MAX_DLY);
  localparam logic [DLY_W-1:0] BASE_V =
    (BASE_DLY > MAX_DLY) ? DLY_W'(MAX_DLY) : DLY_W'(BASE_DLY);

  logic [DLY_W-1:0]  step_q, step_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic [PROD_W-1:0] grown;
  logic              step_en, cnt_en;

  assign grown   = PROD_W'(step_q) * PROD_W'(GROWTH);
  assign expired = (cnt_q == '0);

  // length of the next wait: base, then multiplied per failure, saturating
  always_comb begin
    step_en = restart || arm;
    step_d  = step_q;
    if (restart)
      step_d = BASE_V;
    else if (arm)
      step_d = (grown > PROD_W'(CEIL_V)) ? CEIL_V : grown[DLY_W-1:0];
  end

  // the wait occupies step_q cycles: load step-1, leave when zero
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (arm) begin
      cnt_en = 1'b1;
      cnt_d  = step_q - DLY_W'(1);
    end else if (run && !expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= BASE_V;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tts_cmd_filter.sv
module tts_cmd_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  input  logic in_held,
  input  logic acq_cmd,
  input  logic rel_cmd,
  output logic acq_go,
  output logic rel_go,
  output logic cmd_err
);

  logic err_q, err_d;

  assign acq_go = acq_cmd && in_idle;
  assign rel_go = rel_cmd && in_held;
  assign err_d  = (acq_cmd && !in_idle) || (rel_cmd && !in_held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cmd_err = err_q;

endmodule

// File: rtl/tts_lock_requester.sv
module tts_lock_requester
  import lock_req_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = '0,
  parameter int unsigned       BASE_DLY  = 4,
  parameter int unsigned       GROWTH    = 2,
  parameter int unsigned       MAX_DLY   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_cmd,
  input  logic              rel_cmd,
  output logic              granted,
  output logic              cmd_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [1:0]        mem_req_op,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  logic       rst_n_i;
  lrq_state_e state_q, state_d;
  logic       acq_go, rel_go;
  logic       port_active, port_done;
  logic       bo_arm, bo_restart, bo_run, bo_expired;
  logic       rsp_free;

  tts_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  tts_cmd_filter u_cmd (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .in_idle (state_q == ST_IDLE),
    .in_held (state_q == ST_HELD),
    .acq_cmd (acq_cmd),
    .rel_cmd (rel_cmd),
    .acq_go  (acq_go),
    .rel_go  (rel_go),
    .cmd_err (cmd_err)
  );

  assign port_active = (state_q == ST_POLL) || (state_q == ST_TRY) ||
                       (state_q == ST_RELEASE);

  tts_mem_port u_port (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .active    (port_active),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .req_valid (mem_req_valid),
    .done      (port_done)
  );

  tts_backoff_timer #(
    .BASE_DLY (BASE_DLY),
    .GROWTH   (GROWTH),
    .MAX_DLY  (MAX_DLY)
  ) u_backoff (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .arm     (bo_arm),
    .restart (bo_restart),
    .run     (bo_run),
    .expired (bo_expired)
  );

  assign rsp_free   = (mem_rsp_data == '0);
  assign bo_arm     = (state_q == ST_TRY) && port_done && !rsp_free;
  assign bo_restart = (state_q == ST_TRY) && port_done && rsp_free;
  assign bo_run     = (state_q == ST_BACKOFF);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (acq_go) state_d = ST_POLL;
      ST_POLL:    if (port_done && rsp_free) state_d = ST_TRY;
      ST_TRY:     if (port_done) state_d = rsp_free ? ST_HELD : ST_BACKOFF;
      ST_BACKOFF: if (bo_expired) state_d = ST_POLL;
      ST_HELD:    if (rel_go) state_d = ST_RELEASE;
      ST_RELEASE: if (port_done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_TRY:     mem_req_op = OP_TAS;
      ST_RELEASE: mem_req_op = OP_STORE0;
      default:    mem_req_op = OP_LOAD;
    endcase
  end

  assign mem_req_addr = LOCK_ADDR;
  assign granted      = (state_q == ST_HELD);

endmodule

// File: rtl/tts_lock_requester_chk.sv
module tts_lock_requester_chk
  import lock_req_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acq_cmd,
  input logic              rel_cmd,
  input logic              granted,
  input logic              cmd_err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [1:0]        mem_req_op,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data
);

  logic owed_q;       // a response is still owed
  logic zero_seen_q;  // last load response was zero and no attempt answered yet

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              owed_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) owed_q <= 1'b1;
    else if (mem_rsp_valid)                  owed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zero_seen_q <= 1'b0;
    else if (mem_rsp_valid && owed_q) begin
      if (mem_req_op == OP_LOAD)     zero_seen_q <= (mem_rsp_data == '0);
      else if (mem_req_op == OP_TAS) zero_seen_q <= 1'b0;
    end
  end

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_op));

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q |-> !mem_req_valid);

  a_r3_tas_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_op == OP_TAS |-> zero_seen_q);

  a_r6_grant_follows_win: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(mem_rsp_valid && mem_rsp_data == '0 && mem_req_op == OP_TAS));

  a_r6_quiet_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> !mem_req_valid);

  a_r6_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
    granted && rel_cmd |=> !granted);

  a_r8_acquire_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    granted && acq_cmd && !rel_cmd |=> granted && cmd_err);

  a_r9_release_not_held: assert property (@(posedge clk) disable iff (!rst_n)
    !granted && rel_cmd |=> cmd_err && !granted);

endmodule

bind tts_lock_requester tts_lock_requester_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acq_cmd       (acq_cmd),
  .rel_cmd       (rel_cmd),
  .granted       (granted),
  .cmd_err       (cmd_err),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_op    (mem_req_op),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data)
);

// File: tb/tb_tts_lock_requester.sv
`timescale 1ns/1ps
module tb_tts_lock_requester;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned K      = 4;
  localparam int unsigned C      = 2;
  localparam int unsigned CAP    = 1024;
  localparam logic [1:0] OPC_LOAD = 2'b00;
  localparam logic [1:0] OPC_TAS  = 2'b01;
  localparam logic [1:0] OPC_ST0  = 2'b10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acq_cmd, rel_cmd;
  logic              granted, cmd_err;
  logic              mem_req_valid, mem_req_ready;
  logic [1:0]        mem_req_op;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;

  always #10 clk = ~clk;  // 50 MHz

  tts_lock_requester #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_ADDR(32'h0000_1F40),
    .BASE_DLY(K), .GROWTH(C), .MAX_DLY(CAP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .acq_cmd(acq_cmd), .rel_cmd(rel_cmd),
    .granted(granted), .cmd_err(cmd_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_vec = 0;
  int n_bad = 0;

  // bench model state
  int  lock_val = 0;
  int  comp_timer = 0;
  int  steal_left = 0;
  bit  owns = 0;
  bit  acq_active = 0;
  bit  rel_issued = 0;
  int  fail_i = 0;
  bit  last_load_zero = 0;
  bit  measuring = 0;
  int  gap = 0;
  int  exp_gap = 0;
  int  last_exp_gap = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_delay(input int i);
    longint d = K;
    for (int j = 0; j < i; j++) begin
      d = d * C;
      if (d >= CAP) return CAP;
    end
    return (d > CAP) ? CAP : int'(d);
  endfunction

  // memory, competitor and monitor
  initial begin
    bit       hs = 0;
    bit       pend = 0;
    bit [1:0] hs_op = 2'b00;
    bit [1:0] pend_op = 2'b00;
    int       pend_data = 0;
    int       lat = 0;
    bit [1:0] rsp_op = 2'b00;
    int       rsp_val = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    @(negedge clk);
    while (!rst_n) @(negedge clk);
    forever begin
      @(negedge clk);
      // response consumed at the previous edge
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        if (rsp_op == OPC_TAS) begin
          if (rsp_val == 0) begin
            owns = 1; acq_active = 0; fail_i = 0;
          end else begin
            exp_gap = exp_delay(fail_i);
            last_exp_gap = exp_gap;
            fail_i++;
            measuring = 1; gap = 0;
          end
        end
      end
      // request accepted at the previous edge
      if (hs) begin
        pend = 1; pend_op = hs_op; lat = $urandom % 4;
        case (hs_op)
          OPC_LOAD: begin
            chk(acq_active, "R2", "load without acquire", 0, 1);
            chk(!last_load_zero, "R3", "load after zero load", 1, 0);
            pend_data = lock_val;
            if (lock_val == 0 && steal_left > 0) begin
              steal_left--; lock_val = 1; comp_timer = 30 + $urandom % 20;
            end
          end
          OPC_TAS: begin
            chk(last_load_zero, "R3", "tas without zero load", 0, 1);
            pend_data = lock_val; lock_val = 1;
          end
          OPC_ST0: begin
            chk(rel_issued, "R7", "store without release", 0, 1);
            pend_data = 0; lock_val = 0; rel_issued = 0;
          end
          default: chk(0, "R10", "bad op code", hs_op, 0);
        endcase
        last_load_zero = 0;
      end
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = DATA_W'(pend_data);
          rsp_op = pend_op; rsp_val = pend_data; pend = 0;
          if (pend_op == OPC_LOAD && pend_data == 0) last_load_zero = 1;
        end else lat--;
      end
      if (comp_timer > 0) begin
        comp_timer--;
        if (comp_timer == 0) lock_val = 0;
      end
      mem_req_ready = ($urandom % 4) != 0;
      #1;
      hs = mem_req_valid && mem_req_ready;
      hs_op = mem_req_op;
      chk(granted == owns, "R6", "granted", granted, owns);
      if (granted) chk(!mem_req_valid, "R6", "request while held", mem_req_valid, 0);
      if (measuring) begin
        if (!mem_req_valid) gap++;
        else begin
          chk(gap == exp_gap, "R5", "backoff length", gap, exp_gap);
          chk(mem_req_op == OPC_LOAD, "R4", "op after failed tas", mem_req_op, OPC_LOAD);
          measuring = 0;
        end
      end
    end
  end

  task automatic pulse(input bit is_acq);
    @(negedge clk);
    if (is_acq) acq_cmd = 1'b1; else rel_cmd = 1'b1;
    @(negedge clk);
    acq_cmd = 1'b0; rel_cmd = 1'b0;
  endtask

  task automatic do_acquire(input int limit);
    acq_active = 1;
    pulse(1);
    #2;
    chk(cmd_err == 1'b0, "R2", "error on valid acquire", cmd_err, 0);
    for (int t = 0; t < limit && !granted; t++) @(negedge clk);
    #2;
    chk(granted, "R6", "grant obtained", granted, 1);
  endtask

  task automatic do_release();
    @(negedge clk);
    rel_cmd = 1'b1;
    @(negedge clk);
    rel_cmd = 1'b0; owns = 0; rel_issued = 1;
    for (int t = 0; t < 50 && rel_issued; t++) @(negedge clk);
    chk(!rel_issued, "R7", "store issued", rel_issued, 0);
    repeat (6) @(negedge clk);
    #2;
    chk(!granted && !mem_req_valid, "R7", "idle after release", mem_req_valid, 0);
  endtask

  task automatic misuse_acquire_held();
    pulse(1);
    #2;
    chk(cmd_err == 1'b1, "R8", "error on acquire while held", cmd_err, 1);
    chk(granted == 1'b1, "R8", "grant kept", granted, 1);
    @(negedge clk); #2;
    chk(cmd_err == 1'b0, "R8", "error is one pulse", cmd_err, 0);
  endtask

  task automatic misuse_release_idle();
    pulse(0);
    #2;
    chk(cmd_err == 1'b1, "R9", "error on release while idle", cmd_err, 1);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk); #2;
      chk(!mem_req_valid && !granted, "R9", "no effect of release", mem_req_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; acq_cmd = 1'b0; rel_cmd = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!granted, "R1", "granted in reset", granted, 0);
    chk(!mem_req_valid, "R1", "req in reset", mem_req_valid, 0);
    chk(!cmd_err, "R1", "err in reset", cmd_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #2;
    chk(!granted && !mem_req_valid && !cmd_err, "R1", "quiet after reset",
        {granted, mem_req_valid, cmd_err}, 0);

    // release in idle is ignored
    misuse_release_idle();

    // free lock, no contention
    do_acquire(500);
    misuse_acquire_held();
    do_release();

    // busy lock, acquire again while polling
    lock_val = 1; comp_timer = 80;
    acq_active = 1;
    pulse(1);
    repeat (5) @(negedge clk);
    pulse(1);
    #2;
    chk(cmd_err == 1'b1, "R8", "error on acquire while polling", cmd_err, 1);
    for (int t = 0; t < 2000 && !granted; t++) @(negedge clk);
    #2;
    chk(granted, "R8", "acquisition continues", granted, 1);
    do_release();

    // eleven failures: growth up to the ceiling and beyond
    steal_left = 11;
    do_acquire(20000);
    chk(fail_i == 0, "R5", "failure count reset on success", fail_i, 0);
    do_release();

    // one failure after a success: delay back at the base
    steal_left = 1;
    do_acquire(2000);
    chk(last_exp_gap == K, "R5", "base delay after success", last_exp_gap, K);
    do_release();

    // random rounds
    for (int r = 0; r < 25; r++) begin
      steal_left = $urandom % 4;
      if ($urandom % 2) begin
        lock_val = 1; comp_timer = 10 + $urandom % 40;
      end
      do_acquire(20000);
      repeat ($urandom % 10) @(negedge clk);
      if ($urandom % 2) misuse_acquire_held();
      do_release();
      if ($urandom % 3 == 0) misuse_release_idle();
    end

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule